// File: doc/BRIEF.md
# Sync Timing Measurement Unit

This block watches a pair of separate horizontal and vertical sync inputs and measures their timing against its own reference clock. Each input passes through a two-flop synchronizer before edge detection. For every line it measures the clock count from one hsync rising edge to the next, and the number of clocks hsync stays high. Both measurements are kept as a running smallest/largest pair, so the host can see any one-clock sampling jitter.

The vertical side samples vsync once per line, on the falling edge of hsync. From that sampled sequence it derives the frame length and the vsync high width, both counted in lines. It also works out which sync level is the active pulse, once for hsync and once for vsync.

Firmware reads the results through a simple read strobe and address, and the data comes back one cycle later. Reading the last register of the horizontal group starts a fresh min/max accumulation and refreshes the hsync polarity bit. All counters are 12 bits wide and stop at all ones instead of wrapping.

Top module: `sync_meas_top`

## Requirements
- R1: After reset, reads return 0xFFF at addresses 0 and 2, and zero at addresses 1, 3, 4, 5 and 6.
- R2: A horizontal period sample is the number of clocks between two consecutive hsync rising edges. A hsync width sample is the number of clocks hsync is high, taken at its falling edge. No period sample is taken at the first rising edge after reset.
- R3: Address 0 holds the smallest and address 1 the largest period sample since the last restart. Address 2 holds the smallest and address 3 the largest width sample since the last restart. A new sample updates these registers on every line.
- R4: A read of address 3 returns the values held before the read. From the next cycle it restarts both pairs: minimums become 0xFFF and maximums become 0. The next sample then sets both members of its pair.
- R5: Vsync is sampled at every hsync falling edge. When a sample is 1 and the previous sample was 0, address 4 latches the number of samples since the previous such rise, and address 5 latches how many of those samples were 1. Nothing is latched at the first such rise after reset.
- R6: Address 6 bit 0 is the hsync polarity. It is loaded only when address 3 is read. It is set to 1 when the last complete high width is shorter than the last complete low width, and to 0 otherwise.
- R7: Address 6 bit 1 is the vsync polarity. It is updated when address 4 latches, and is set to 1 when the frame had fewer high samples than low samples.
- R8: All counts saturate at 4095. A hsync period or high time longer than 4095 clocks reads as 4095.
- R9: rd_data shows the addressed register one cycle after rd_en, as a 12-bit value zero-extended to 16 bits. It holds its value while rd_en is low. Addresses 7 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference timing clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Asynchronous horizontal sync |
| vsync_in | input | 1 | Asynchronous vertical sync |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register address |
| rd_data | output | 16 | Read data, valid the cycle after rd_en |

## Verification
The assertions check four properties on every cycle:
- each minimum stays at or below its maximum once a sample exists;
- a restart read loads the fixed restart values;
- the maximums never shrink between restarts;
- the hsync polarity bit, the frame length and the read data stay stable between their update events.

The exact counts are left to the bench. It drives lines and frames with random high and low times and checks the saturated count on an over-long line. It also checks the polarity decisions, the skipped first samples and the read-back ordering around a restart, using its own line-by-line model.

// File: rtl/sync_meas_pkg.sv
package sync_meas_pkg;

    localparam int CNT_W  = 12;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_HPER_MIN = 4'd0,
        RA_HPER_MAX = 4'd1,
        RA_HWID_MIN = 4'd2,
        RA_HWID_MAX = 4'd3,
        RA_VPER     = 4'd4,
        RA_VWID     = 4'd5,
        RA_POL      = 4'd6
    } reg_addr_e;

    // Synchronized level plus single-cycle edge flags
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } sync_ev_t;

    typedef struct packed {
        logic             vld;
        logic [CNT_W-1:0] val;
    } sample_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/sync_meas_sync.sv
module sync_meas_sync
    import sync_meas_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output sync_ev_t ev
);
    localparam int LAST = STAGES;

    logic [LAST:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[LAST-1:0], din};
    end

    always_comb begin
        ev.level = pipe[LAST-1];
        ev.rise  = pipe[LAST-1] & ~pipe[LAST];
        ev.fall  = ~pipe[LAST-1] & pipe[LAST];
    end
endmodule

// File: rtl/sync_meas_minmax.sv
module sync_meas_minmax
    import sync_meas_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  sample_t          smp,
    output logic [CNT_W-1:0] lo,
    output logic [CNT_W-1:0] hi
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lo <= '1;
            hi <= '0;
        end else if (smp.vld) begin
            if (smp.val < lo) lo <= smp.val;
            if (smp.val > hi) hi <= smp.val;
        end
    end
endmodule

// File: rtl/sync_meas_horiz.sv
module sync_meas_horiz
    import sync_meas_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sync_ev_t hs,
    input  logic     restart,
    output sample_t  per_smp,
    output sample_t  wid_smp,
    output logic     hpol
);
    logic [CNT_W-1:0] per_cnt, hi_cnt, lo_cnt;
    logic [CNT_W-1:0] hi_last, lo_last;
    logic             seen_rise, seen_fall;

    always_comb begin
        per_smp.vld = hs.rise & seen_rise;
        per_smp.val = per_cnt;
        wid_smp.vld = hs.fall & seen_rise;
        wid_smp.val = hi_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_cnt   <= '0;
            hi_cnt    <= '0;
            lo_cnt    <= '0;
            hi_last   <= '0;
            lo_last   <= '0;
            seen_rise <= 1'b0;
            seen_fall <= 1'b0;
            hpol      <= 1'b0;
        end else begin
            // period counter: restarts at each rising edge
            if (hs.rise) begin
                per_cnt   <= CNT_W'(1);
                seen_rise <= 1'b1;
            end else begin
                per_cnt <= sat_inc(per_cnt);
            end

            // high time
            if (hs.rise)           hi_cnt <= CNT_W'(1);
            else if (hs.level)     hi_cnt <= sat_inc(hi_cnt);
            if (hs.fall && seen_rise) hi_last <= hi_cnt;

            // low time
            if (hs.fall) begin
                lo_cnt    <= CNT_W'(1);
                seen_fall <= 1'b1;
            end else if (!hs.level) begin
                lo_cnt <= sat_inc(lo_cnt);
            end
            if (hs.rise && seen_fall) lo_last <= lo_cnt;

            // polarity refreshed on host restart
            if (restart) hpol <= (hi_last < lo_last);
        end
    end
endmodule

// File: rtl/sync_meas_vert.sv
module sync_meas_vert
    import sync_meas_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_tick,
    input  logic             vs_level,
    output logic [CNT_W-1:0] vper,
    output logic [CNT_W-1:0] vwid,
    output logic             vpol
);
    logic [CNT_W-1:0] line_cnt, high_cnt;
    logic             vs_prev, seen;
    logic             frame_mark;

    assign frame_mark = vs_level & ~vs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_cnt <= '0;
            high_cnt <= '0;
            vs_prev  <= 1'b0;
            seen     <= 1'b0;
            vper     <= '0;
            vwid     <= '0;
            vpol     <= 1'b0;
        end else if (line_tick) begin
            vs_prev <= vs_level;
            if (frame_mark) begin
                if (seen) begin
                    vper <= line_cnt;
                    vwid <= high_cnt;
                    vpol <= (high_cnt < (line_cnt - high_cnt));
                end
                line_cnt <= CNT_W'(1);
                high_cnt <= CNT_W'(1);
                seen     <= 1'b1;
            end else begin
                line_cnt <= sat_inc(line_cnt);
                if (vs_level) high_cnt <= sat_inc(high_cnt);
            end
        end
    end
endmodule

// File: rtl/sync_meas_top.sv
module sync_meas_top
    import sync_meas_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAD_W = DATA_W - CNT_W;

    sync_ev_t         hs_ev, vs_ev;
    sample_t          per_smp, wid_smp;
    logic [CNT_W-1:0] hper_lo, hper_hi, hwid_lo, hwid_hi;
    logic [CNT_W-1:0] vper, vwid;
    logic             hpol, vpol;
    logic             restart;
    logic [CNT_W-1:0] sel_val;

    assign restart = rd_en && (rd_addr == RA_HWID_MAX);

    sync_meas_sync #(.STAGES(SYNC_STAGES)) u_hs_sync (
        .clk(clk), .rst(rst), .din(hsync_in), .ev(hs_ev));
    sync_meas_sync #(.STAGES(SYNC_STAGES)) u_vs_sync (
        .clk(clk), .rst(rst), .din(vsync_in), .ev(vs_ev));

    sync_meas_horiz u_horiz (
        .clk(clk), .rst(rst), .hs(hs_ev), .restart(restart),
        .per_smp(per_smp), .wid_smp(wid_smp), .hpol(hpol));

    sync_meas_minmax u_per_mm (
        .clk(clk), .rst(rst), .clr(restart), .smp(per_smp),
        .lo(hper_lo), .hi(hper_hi));
    sync_meas_minmax u_wid_mm (
        .clk(clk), .rst(rst), .clr(restart), .smp(wid_smp),
        .lo(hwid_lo), .hi(hwid_hi));

    sync_meas_vert u_vert (
        .clk(clk), .rst(rst), .line_tick(hs_ev.fall), .vs_level(vs_ev.level),
        .vper(vper), .vwid(vwid), .vpol(vpol));

    always_comb begin
        case (rd_addr)
            RA_HPER_MIN: sel_val = hper_lo;
            RA_HPER_MAX: sel_val = hper_hi;
            RA_HWID_MIN: sel_val = hwid_lo;
            RA_HWID_MAX: sel_val = hwid_hi;
            RA_VPER:     sel_val = vper;
            RA_VWID:     sel_val = vwid;
            RA_POL:      sel_val = {{(CNT_W-2){1'b0}}, vpol, hpol};
            default:     sel_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= {{PAD_W{1'b0}}, sel_val};
    end
endmodule

// File: rtl/sync_meas_chk.sv
module sync_meas_chk
    import sync_meas_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  hper_lo,
    input logic [CNT_W-1:0]  hper_hi,
    input logic [CNT_W-1:0]  hwid_lo,
    input logic [CNT_W-1:0]  hwid_hi,
    input logic              hpol,
    input logic [CNT_W-1:0]  vper,
    input logic              line_tick
);
    logic rs;
    assign rs = rd_en && (rd_addr == RA_HWID_MAX);

    AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (rst)
        (hper_hi != '0) |-> (hper_lo <= hper_hi)); // R3

    AST_WID_MIN_LE_MAX: assert property (@(posedge clk) disable iff (rst)
        (hwid_hi != '0) |-> (hwid_lo <= hwid_hi)); // R3

    AST_MAX_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        !rs |=> (hper_hi >= $past(hper_hi))); // R3

    AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (rst)
        rs |=> (hper_lo == '1 && hper_hi == '0 && hwid_lo == '1 && hwid_hi == '0)); // R4

    AST_HPOL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rs |=> $stable(hpol)); // R6

    AST_VPER_HOLD: assert property (@(posedge clk) disable iff (rst)
        !line_tick |=> $stable(vper)); // R5

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R9
endmodule

bind sync_meas_top sync_meas_chk u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .hper_lo(hper_lo), .hper_hi(hper_hi), .hwid_lo(hwid_lo), .hwid_hi(hwid_hi),
    .hpol(hpol), .vper(vper), .line_tick(hs_ev.fall));

// File: tb/sync_meas_top_tb_top.sv
`timescale 1ns/1ps
module sync_meas_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hsync_in = 1'b0;
    logic        vsync_in = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // expected-state model
    int  pmin = 4095, pmax = 0, wmin = 4095, wmax = 0;
    int  last_h = 0, last_l = 0, hpol_e = 0;
    int  prev_h = 0, prev_l = 0;
    bit  have_prev = 0;
    bit  vprev = 0, vseen = 0;
    int  lcnt = 0, hcnt = 0, vper_e = 0, vwid_e = 0, vpol_e = 0;

    always #2.5 clk = ~clk;

    sync_meas_top dut_i (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

    function automatic int sat(input int x);
        return (x > 4095) ? 4095 : x;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output int d);
        rd_en = 1'b1;
        rd_addr = 4'(a);
        tick(1);
        rd_en = 1'b0;
        d = int'(rd_data);
    endtask

    // Read all registers; address 3 restarts the horizontal model (R4, R6)
    task automatic read_all;
        int d;
        rd(0, d); check("R3 period min", d, pmin);
        rd(1, d); check("R3 period max", d, pmax);
        rd(2, d); check("R3 width min", d, wmin);
        rd(3, d); check("R4 width max before restart", d, wmax);
        pmin = 4095; pmax = 0; wmin = 4095; wmax = 0;
        hpol_e = (last_h < last_l) ? 1 : 0;
        rd(4, d); check("R5 vertical period", d, vper_e);
        rd(5, d); check("R5 vsync width", d, vwid_e);
        rd(6, d); check("R6 R7 polarity", d, (vpol_e << 1) | hpol_e);
    endtask

    task automatic run_line(input int h, input int l, input bit v, input bit do_rd);
        int p;
        vsync_in = v;
        hsync_in = 1'b1;
        if (have_prev) begin
            p = sat(prev_h + prev_l);           // R2, R8
            if (p < pmin) pmin = p;
            if (p > pmax) pmax = p;
            last_l = sat(prev_l);
        end
        tick(h);
        hsync_in = 1'b0;
        if (sat(h) < wmin) wmin = sat(h);
        if (sat(h) > wmax) wmax = sat(h);
        last_h = sat(h);
        // vertical sample at hsync falling edge (R5, R7)
        if (v && !vprev) begin
            if (vseen) begin
                vper_e = lcnt; vwid_e = hcnt;
                vpol_e = (hcnt < lcnt - hcnt) ? 1 : 0;
            end
            lcnt = 1; hcnt = 1; vseen = 1;
        end else begin
            lcnt = sat(lcnt + 1);
            if (v) hcnt = sat(hcnt + 1);
        end
        vprev = v;
        tick(6);
        if (do_rd) begin
            read_all;
            tick(l - 13);
        end else begin
            tick(l - 6);
        end
        prev_h = h; prev_l = l; have_prev = 1;
    endtask

    initial begin
        void'($urandom(32'd2024));
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int d;
        tick(4);
        rst = 1'b0;
        tick(2);

        // R1 reset state
        rd(0, d); check("R1 period min reset", d, 4095);
        rd(1, d); check("R1 period max reset", d, 0);
        rd(2, d); check("R1 width min reset", d, 4095);
        rd(3, d); check("R1 width max reset", d, 0);
        rd(4, d); check("R1 vper reset", d, 0);
        rd(5, d); check("R1 vwid reset", d, 0);
        rd(6, d); check("R1 polarity reset", d, 0);

        // R9 unused address and hold
        rd(9, d); check("R9 unused address", d, 0);
        rd(1, d);
        tick(3);
        check("R9 hold without rd_en", int'(rd_data), 0);

        // R2 R3 directed: steady lines, then a jittered set
        run_line(10, 40, 0, 0);
        run_line(10, 40, 0, 0);
        run_line(10, 40, 0, 1);
        run_line(12, 41, 0, 0);
        run_line(9, 43, 0, 0);
        run_line(20, 30, 0, 1);

        // R6 hsync long high, short low -> negative
        run_line(50, 30, 0, 0);
        run_line(50, 30, 0, 1);

        // R5 R7 random frames with random line shapes
        for (int f = 0; f < 12; f++) begin
            int a, b;
            a = 1 + int'($urandom % 4);
            b = 3 + int'($urandom % 8);
            if (f % 3 == 2) begin a = b + 2; end
            for (int i = 0; i < a + b; i++) begin
                run_line(4 + int'($urandom % 40), 30 + int'($urandom % 50),
                         (i < a), (i == 0));
            end
        end

        // R8 saturation on an over-long line
        run_line(5000, 40, 0, 0);
        run_line(10, 40, 0, 1);
        run_line(10, 40, 0, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule